// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank with Interrupts

This block is a bank of up to 32 general-purpose pins that software reaches through a small word-addressed register port. Each pin can be an input or an output. Software can write the output value as a whole word, or change single bits without a read-modify-write through separate set and clear locations. The direction register chooses which pins drive, and the output value register holds what they drive. A read of the data location returns what software sees on each pin: the synchronized pad level for inputs and the driven value for outputs.

Pad inputs pass through a two-flop synchronizer. A rising edge of the synchronized level sets a sticky bit in a capture register, and software clears that bit by writing a 1 back to it. A per-pin enable mask picks which pins may raise the single interrupt line. A build-time parameter selects the interrupt source for the whole bank. In edge mode the source is the captured edges. In level mode it is the current data view. The output enable and output value leave the block as separate buses, and the pad cells sit outside it.

Top module: `gpio_bank`

## Requirements
- R1: While `rst` is high, and after it falls until the first access, `pin_out`, `pin_oe`, `irq` and `rdata` are all zero. The output, direction, mask and capture registers reset to zero.
- R2: Word address map on `addr`: 0 data, 1 direction, 2 interrupt mask, 3 edge capture, 4 output set, 5 output clear. These are byte offsets 0x0, 0x4, 0x8, 0xC, 0x10 and 0x14. Addresses 6 and 7 read zero and writes to them change nothing. A read strobe loads `rdata` at that clock edge, and `rdata` holds its value otherwise.
- R3: Register bits at or above `PINS` read as zero, and written values there are dropped.
- R4: `pin_oe` equals the direction register, where 1 means output, and `pin_out` equals the output value register. A value written to data while a pin is still an input appears on `pin_out` at once, so the pin drives it from the same cycle its direction bit is set.
- R5: Reading data returns the output value for pins whose direction bit is 1, and the synchronized `pin_in` for pins whose direction bit is 0. A change on `pin_in` before clock edge k is seen by a read strobe at edge k+2.
- R6: A write to address 4 ORs the written bits into the output value. A write to address 5 clears the written bits. No other bit changes, and both addresses read zero.
- R7: In edge mode, a 0-to-1 change of a synchronized pin sets its capture bit. For a `pin_in` change before edge k, the bit is set at edge k+2. A falling level sets nothing.
- R8: The capture register is write-1-to-clear: written 1s clear, written 0s leave bits alone. An edge arriving in the same cycle as a clear of that bit leaves the bit set.
- R9: In edge mode, `irq` is registered and is high one cycle after any bit of (capture AND mask) is set.
- R10: In level mode, `irq` is registered and is high one cycle after any bit of (data view AND mask) is set. The capture register reads zero.
- R11: A pin whose mask bit is 0 never causes `irq`. With the mask all zero, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 3 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| pin_in | input | PINS | Pad input levels, asynchronous |
| pin_out | output | PINS | Value driven to the pads |
| pin_oe | output | PINS | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong bit in the output or direction register shows on `pin_out` or `pin_oe` in the next cycle. It is also visible through any read. A capture bit that is lost, stuck or wrongly set only shows once software reads address 3, or on `irq` one cycle after the matching mask bit is enabled. The bench therefore runs a reference model in step with the design and compares the pin buses, `irq` and `rdata` at every clock. That way a corrupted capture or synchronizer stage is caught within about three cycles of the stimulus that exposes it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_MASK = 3'd2,
        SEL_CAP  = 3'd3,
        SEL_SET  = 3'd4,
        SEL_CLR  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic data;
        logic dir;
        logic mask;
        logic cap;
        logic set;
        logic clr;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic we, input logic [ADDR_W-1:0] a);
        wr_dec_t d;
        d.data = we && (a == SEL_DATA);
        d.dir  = we && (a == SEL_DIR);
        d.mask = we && (a == SEL_MASK);
        d.cap  = we && (a == SEL_CAP);
        d.set  = we && (a == SEL_SET);
        d.clr  = we && (a == SEL_CLR);
        return d;
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_sync,
    output logic [W-1:0] pin_rise
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign pin_sync = sync_q;
    assign pin_rise = sync_q & ~prev_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  wr_dec_t      dec,
    input  logic [W-1:0] wval,
    output logic [W-1:0] out_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else begin
            if (dec.data)
                out_q <= wval;
            else if (dec.set)
                out_q <= out_q | wval;
            else if (dec.clr)
                out_q <= out_q & ~wval;
            if (dec.dir)
                dir_q <= wval;
            if (dec.mask)
                mask_q <= wval;
        end
    end
endmodule

// File: rtl/gpio_bank_capture.sv
module gpio_bank_capture #(
    parameter int W         = 32,
    parameter bit EDGE_MODE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] rise,
    output logic [W-1:0] cap_q
);
    generate
        if (EDGE_MODE) begin : g_edge
            logic [W-1:0] held_q;
            logic [W-1:0] wipe;
            assign wipe = clr_en ? clr_bits : '0;
            // a new edge outranks a clear in the same cycle
            always_ff @(posedge clk) begin
                if (rst)
                    held_q <= '0;
                else
                    held_q <= (held_q & ~wipe) | rise;
            end
            assign cap_q = held_q;
        end else begin : g_level
            assign cap_q = '0;
        end
    endgenerate
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int PINS      = 32,
    parameter bit EDGE_MODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);
    wr_dec_t          dec;
    logic [PINS-1:0]  wval;
    logic [PINS-1:0]  sync_v, rise_v;
    logic [PINS-1:0]  out_q, dir_q, mask_q, cap_q;
    logic [PINS-1:0]  view, pending;
    logic [BUS_W-1:0] rd_mux;
    logic             irq_q;
    logic [BUS_W-1:0] rdata_q;

    assign dec  = decode_write(wr_en, addr);
    assign wval = wdata[PINS-1:0];

    gpio_bank_sync #(.W(PINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_raw  (pin_in),
        .pin_sync (sync_v),
        .pin_rise (rise_v)
    );

    gpio_bank_ctrl #(.W(PINS)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .dec    (dec),
        .wval   (wval),
        .out_q  (out_q),
        .dir_q  (dir_q),
        .mask_q (mask_q)
    );

    gpio_bank_capture #(.W(PINS), .EDGE_MODE(EDGE_MODE)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (dec.cap),
        .clr_bits (wval),
        .rise     (rise_v),
        .cap_q    (cap_q)
    );

    assign view = (dir_q & out_q) | (~dir_q & sync_v);

    generate
        if (EDGE_MODE) begin : g_pend_edge
            assign pending = cap_q & mask_q;
        end else begin : g_pend_level
            assign pending = view & mask_q;
        end
    endgenerate

    always_comb begin
        case (addr)
            SEL_DATA: rd_mux = BUS_W'(view);
            SEL_DIR:  rd_mux = BUS_W'(dir_q);
            SEL_MASK: rd_mux = BUS_W'(mask_q);
            SEL_CAP:  rd_mux = BUS_W'(cap_q);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            irq_q <= |pending;
            if (rd_en)
                rdata_q <= rd_mux;
        end
    end

    assign irq     = irq_q;
    assign rdata   = rdata_q;
    assign pin_out = out_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int PINS = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [2:0]      addr,
    input logic [31:0]     wdata,
    input logic [31:0]     rdata,
    input logic [PINS-1:0] pin_out,
    input logic [PINS-1:0] pin_oe,
    input logic            irq,
    input logic [PINS-1:0] cap,
    input logic [PINS-1:0] mask
);
    logic [PINS-1:0] wbits;
    logic [PINS-1:0] keep;
    assign wbits = wdata[PINS-1:0];
    assign keep  = cap & ~((wr_en && addr == 3'd3) ? wbits : '0);

    // R11: an all-zero mask keeps the interrupt low
    a_r11_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |=> !irq);

    // R8: capture bits not written with 1 survive the next edge
    a_r8_sticky_capture: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cap & $past(keep)) == $past(keep)));

    // R6: set location forces its bits high
    a_r6_set_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd4) |=> ((pin_out & $past(wbits)) == $past(wbits)));

    // R6: clear location forces its bits low
    a_r6_clear_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd5) |=> ((pin_out & $past(wbits)) == '0));

    // R4: output enables move only on a direction write
    a_r4_oe_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == 3'd1) |=> $stable(pin_oe));

    // R3: bits beyond the pin count read zero
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        ((rdata >> PINS) == 32'd0));
endmodule

bind gpio_bank gpio_bank_chk #(.PINS(PINS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq),
    .cap     (cap_q),
    .mask    (mask_q)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
    localparam int P = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [P-1:0] pins = '0;
    logic [31:0]  rdata, rdata_l;
    logic [P-1:0] pout, poe, pout_l, poe_l;
    logic         irq, irq_l;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    gpio_bank #(.PINS(P), .EDGE_MODE(1'b1)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pins), .pin_out(pout),
        .pin_oe(poe), .irq(irq)
    );

    gpio_bank #(.PINS(P), .EDGE_MODE(1'b0)) uut_lvl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_l), .pin_in(pins), .pin_out(pout_l),
        .pin_oe(poe_l), .irq(irq_l)
    );

    // reference model
    logic [P-1:0] m_s1, m_s2, m_p, m_out, m_dir, m_mask, m_cap;
    logic         m_irq_e, m_irq_l;
    logic [31:0]  m_rd_e, m_rd_l;
    logic [P-1:0] m_view;
    assign m_view = (m_dir & m_out) | (~m_dir & m_s2);

    always @(posedge clk) begin : model
        logic [P-1:0] w, clr;
        w   = wdata[P-1:0];
        clr = (wr_en && addr == 3'd3) ? w : '0;
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_p <= '0; m_out <= '0; m_dir <= '0;
            m_mask <= '0; m_cap <= '0; m_irq_e <= 1'b0; m_irq_l <= 1'b0;
            m_rd_e <= '0; m_rd_l <= '0;
        end else begin
            m_s1 <= pins; m_s2 <= m_s1; m_p <= m_s2;
            m_cap <= (m_cap & ~clr) | (m_s2 & ~m_p);
            if (wr_en) begin
                case (addr)
                    3'd0: m_out  <= w;
                    3'd1: m_dir  <= w;
                    3'd2: m_mask <= w;
                    3'd4: m_out  <= m_out | w;
                    3'd5: m_out  <= m_out & ~w;
                    default: ;
                endcase
            end
            m_irq_e <= |(m_cap & m_mask);
            m_irq_l <= |(m_view & m_mask);
            if (rd_en) begin
                case (addr)
                    3'd0: begin m_rd_e <= 32'(m_view); m_rd_l <= 32'(m_view); end
                    3'd1: begin m_rd_e <= 32'(m_dir);  m_rd_l <= 32'(m_dir);  end
                    3'd2: begin m_rd_e <= 32'(m_mask); m_rd_l <= 32'(m_mask); end
                    3'd3: begin m_rd_e <= 32'(m_cap);  m_rd_l <= '0;         end
                    default: begin m_rd_e <= '0; m_rd_l <= '0; end
                endcase
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check("R4/R6 pin_out",      32'(pout),    32'(m_out));
            check("R4 pin_oe",          32'(poe),     32'(m_dir));
            check("R4/R6 pin_out lvl",  32'(pout_l),  32'(m_out));
            check("R9 irq edge",        32'(irq),     32'(m_irq_e));
            check("R10 irq level",      32'(irq_l),   32'(m_irq_l));
            check("R5 rdata edge",      rdata,        m_rd_e);
            check("R5 rdata level",     rdata_l,      m_rd_l);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] e, output logic [31:0] l);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        e = rdata; l = rdata_l;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [31:0] e, l;
        pins = 12'h3C5;
        repeat (3) @(negedge clk);
        check("R1 pin_out reset", 32'(pout), 32'h0);
        check("R1 pin_oe reset",  32'(poe),  32'h0);
        check("R1 irq reset",     32'(irq) | 32'(irq_l), 32'h0);
        check("R1 rdata reset",   rdata, 32'h0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        rd(3'd0, e, l);
        check("R5 input view", e, 32'h3C5);
        check("R5 input view lvl", l, 32'h3C5);

        wr(3'd0, 32'hFFFF_F0F0);
        check("R4 value before dir", 32'(pout), 32'h0F0);
        check("R4 oe still off", 32'(poe), 32'h0);
        rd(3'd0, e, l);
        check("R5 inputs unaffected by data write", e, 32'h3C5);

        wr(3'd1, 32'hFFFF_F0FF);
        check("R4 drives at once", 32'(pout & poe), 32'h0F0);
        rd(3'd1, e, l);
        check("R3 upper bits dropped", e, 32'h0FF);
        rd(3'd0, e, l);
        check("R5 mixed view", e, 32'h3F0);

        wr(3'd4, 32'h0000_0F0F);
        check("R6 set", 32'(pout), 32'hFFF);
        wr(3'd5, 32'h0000_0033);
        check("R6 clear", 32'(pout), 32'hFCC);
        rd(3'd4, e, l);
        check("R6 set reads zero", e, 32'h0);
        rd(3'd5, e, l);
        check("R6 clear reads zero", e, 32'h0);
        rd(3'd6, e, l);
        check("R2 unused reads zero", e, 32'h0);
        wr(3'd7, 32'hFFFF_FFFF);
        check("R2 unused write out", 32'(pout), 32'hFCC);
        check("R2 unused write oe",  32'(poe),  32'h0FF);

        rd(3'd3, e, l);
        check("R7 rises after reset captured", e, 32'h3C5);
        check("R10 level capture reads zero", l, 32'h0);
        check("R11 no irq with mask zero", 32'(irq) | 32'(irq_l), 32'h0);

        wr(3'd2, 32'h0000_0001);
        @(negedge clk);
        check("R9 edge irq", 32'(irq), 32'h1);
        check("R10 level irq low", 32'(irq_l), 32'h0);

        wr(3'd3, 32'h0000_0001);
        @(negedge clk);
        check("R8 irq drops after clear", 32'(irq), 32'h0);
        rd(3'd3, e, l);
        check("R8 other bits kept", e, 32'h3C4);

        wr(3'd2, 32'h0000_0004);
        @(negedge clk);
        check("R10 level irq from output", 32'(irq_l), 32'h1);

        wr(3'd3, 32'h0000_0100);
        pins = 12'h2C5;
        repeat (5) @(negedge clk);
        rd(3'd3, e, l);
        check("R7 falling not captured", e, 32'h2C4);

        pins = pins | 12'h400;
        @(negedge clk);
        @(negedge clk);
        wr(3'd3, 32'h0000_0400);
        rd(3'd3, e, l);
        check("R8 edge beats clear", e, 32'h6C4);

        wr(3'd2, 32'h0000_0800);
        repeat (3) @(negedge clk);
        check("R11 masked pins silent", 32'(irq) | 32'(irq_l), 32'h0);
        pins = pins | 12'h800;
        repeat (4) @(negedge clk);
        check("R10 level irq from input", 32'(irq_l), 32'h1);
        check("R9 edge irq from input", 32'(irq), 32'h1);

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule